// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Flags

The block holds two 16-bit down-counters behind an 8-bit register port, plus the flag, enable and interrupt logic they share with a shift-register event source. Timer one counts on `t1_tick_i`. A mode bit chooses how it behaves at expiry: in one-shot mode it raises a single interrupt and keeps counting down, and in free-running mode it reloads from its latch and raises an interrupt every period. Timer two counts on its own, slower tick `t2_tick_i` and is always one-shot. It is loaded through a split latch: writing its low byte only stages that byte, and writing its high byte commits the full latch to the counter.

Each expiry sets its own bit in a flag register. The interrupt output is the OR of the flags masked by an enable register. A flag clears on a write of one to its bit in the flag register, and also on that timer's acknowledge access: a read of the counter's low byte, or a write of its high byte. The host updates the enable register with set/clear semantics selected by data bit 7.

Top module: `dual_tmr`

Register addresses: 0 timer-1 counter low (write: latch low), 1 timer-1 counter high (write: latch high and load), 2 timer-1 latch low, 3 timer-1 latch high, 4 timer-2 low, 5 timer-2 high, 6 mode (bit 0: 1 = free-running), 7 flags, 8 enables. Flag and enable bit positions are: bit 0 shift-register event, bit 1 timer 2, bit 2 timer 1. Reads return 0 at unused bits.

## Requirements
- R1: After reset, both latches hold 0xFFFF, both counters hold 0xFFFF, the mode is one-shot, and all flags, enables and `irq_o` are 0.
- R2: A write to address 4 places the data in timer-2 latch bits 7:0. It changes neither the timer-2 counter nor the timer-2 flag (bit 1).
- R3: A write to address 5 places the data in timer-2 latch bits 15:8, loads the counter with the whole latch in the next cycle, and clears flag bit 1.
- R4: A read of address 4 returns timer-2 counter bits 7:0 and clears flag bit 1. `irq_o` reflects the cleared flag right after that clock edge.
- R5: A read of address 5 returns timer-2 counter bits 15:8 and leaves the flags unchanged.
- R6: Timer 2 decrements by one on each cycle with `t2_tick_i` high, and only then. A tick at zero wraps the counter to 0xFFFF and sets flag bit 1, but only once per load: later zero crossings before the next address-5 write do not set it again.
- R7: In one-shot mode (address 6 bit 0 = 0), timer 1 decrements on `t1_tick_i`. A tick at zero sets flag bit 2 once per load and wraps the counter to 0xFFFF.
- R8: In free-running mode (address 6 bit 0 = 1), a timer-1 tick at zero reloads the counter from the timer-1 latch and sets flag bit 2 every time, giving a period of latch+1 ticks.
- R9: A write to address 1 loads the timer-1 counter with {data, latch bits 7:0} and clears flag bit 2. A read of address 0 returns counter bits 7:0 and clears flag bit 2.
- R10: Writing 1 to bits 2:0 of address 7 clears the matching flags. A read of address 7 returns the flags in bits 2:0 and, in bit 7, the OR of all enabled pending flags.
- R11: A write to address 8 with data bit 7 = 1 sets the enables given by bits 2:0. With bit 7 = 0 it clears them. A read returns the enables in bits 2:0.
- R12: `irq_o` is 1 exactly when some flag in bits 2:0 is set together with its enable.
- R13: A cycle with `sr_evt_i` high sets flag bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t1_tick_i | input | 1 | Count enable for timer 1 |
| t2_tick_i | input | 1 | Count enable for timer 2 |
| sr_evt_i | input | 1 | Shift-register interrupt event |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read side effects apply) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle `rd_en_i` is high |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong armed bit or a wrong flag priority shows at `irq_o` and at flag bit 7 on the first expiry after a load. It can also stay hidden until the counter completes a full 65536-tick wrap, so the bench runs one complete timer-2 wrap. A latch byte written into the wrong lane shows on the first counter read after the next high-byte load. A wrong free-running reload shows at the counter one cycle after the zero-tick. An error in the mask or the clear decode shows at `irq_o` in the cycle after the faulty write, and the bench sweeps all 64 combinations of flag and enable.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;
  localparam int NUM_SRC = 3;

  // register addresses
  localparam int A_T1_LO     = 0;
  localparam int A_T1_HI     = 1;
  localparam int A_T1_LAT_LO = 2;
  localparam int A_T1_LAT_HI = 3;
  localparam int A_T2_LO     = 4;
  localparam int A_T2_HI     = 5;
  localparam int A_MODE      = 6;
  localparam int A_FLAG      = 7;
  localparam int A_MASK      = 8;

  // flag / enable bit positions
  localparam int FLG_SR = 0;
  localparam int FLG_T2 = 1;
  localparam int FLG_T1 = 2;
endpackage

// File: rtl/dual_tmr_cnt.sv
module dual_tmr_cnt #(
  parameter int CNT_W      = 16,
  parameter bit HAS_RELOAD = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reload_en_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             do_reload;
  logic             at_zero;

  generate
    if (HAS_RELOAD) begin : g_reload
      assign do_reload = reload_en_i;
    end else begin : g_oneshot
      logic unused_rl;
      assign unused_rl = reload_en_i ^ (^reload_val_i);
      assign do_reload = 1'b0;
    end
  endgenerate

  assign at_zero  = (cnt_q == '0);
  // a load in the same cycle wins over the zero crossing
  assign expire_o = tick_i & at_zero & ~load_i & (armed_q | do_reload);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '1;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      armed_q <= 1'b1;
    end else if (tick_i) begin
      if (at_zero) begin
        if (do_reload) begin
          cnt_q <= (HAS_RELOAD) ? reload_val_i : '1;
        end else begin
          cnt_q   <= '1;
          armed_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dual_tmr_irq.sv
module dual_tmr_irq #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_wr_i,
  input  logic               en_set_i,
  input  logic [NUM_SRC-1:0] en_bits_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] en_q;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      // a new event wins over a simultaneous clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        flag_q[i] <= 1'b0;
        else if (set_i[i])  flag_q[i] <= 1'b1;
        else if (clr_i[i])  flag_q[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (en_wr_i)   en_q <= en_set_i ? (en_q | en_bits_i) : (en_q & ~en_bits_i);
  end

  assign flags_o = flag_q;
  assign en_o    = en_q;
  assign irq_o   = |(flag_q & en_q);
endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
  import dual_tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              t1_tick_i,
  input  logic              t2_tick_i,
  input  logic              sr_evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int r);
    return a == ADDR_W'(r);
  endfunction

  logic w_t1_lo, w_t1_hi, w_t1_llo, w_t1_lhi, w_t2_lo, w_t2_hi;
  logic w_mode, w_flag, w_mask, r_t1_lo, r_t2_lo;

  assign w_t1_lo  = wr_en_i & hit(addr_i, A_T1_LO);
  assign w_t1_hi  = wr_en_i & hit(addr_i, A_T1_HI);
  assign w_t1_llo = wr_en_i & hit(addr_i, A_T1_LAT_LO);
  assign w_t1_lhi = wr_en_i & hit(addr_i, A_T1_LAT_HI);
  assign w_t2_lo  = wr_en_i & hit(addr_i, A_T2_LO);
  assign w_t2_hi  = wr_en_i & hit(addr_i, A_T2_HI);
  assign w_mode   = wr_en_i & hit(addr_i, A_MODE);
  assign w_flag   = wr_en_i & hit(addr_i, A_FLAG);
  assign w_mask   = wr_en_i & hit(addr_i, A_MASK);
  assign r_t1_lo  = rd_en_i & hit(addr_i, A_T1_LO);
  assign r_t2_lo  = rd_en_i & hit(addr_i, A_T2_LO);

  logic [CNT_W-1:0] t1_lat, t2_lat, t1_lat_d, t2_lat_d;
  logic [CNT_W-1:0] t1_cnt, t2_cnt;
  logic             mode_free;
  logic             t1_exp, t2_exp;

  always_comb begin
    t1_lat_d = t1_lat;
    if (w_t1_lo | w_t1_llo) t1_lat_d[DATA_W-1:0]     = wdata_i;
    if (w_t1_hi | w_t1_lhi) t1_lat_d[CNT_W-1:DATA_W] = wdata_i;
    t2_lat_d = t2_lat;
    if (w_t2_lo)            t2_lat_d[DATA_W-1:0]     = wdata_i;
    if (w_t2_hi)            t2_lat_d[CNT_W-1:DATA_W] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_lat    <= '1;
      t2_lat    <= '1;
      mode_free <= 1'b0;
    end else begin
      t1_lat <= t1_lat_d;
      t2_lat <= t2_lat_d;
      if (w_mode) mode_free <= wdata_i[0];
    end
  end

  dual_tmr_cnt #(.CNT_W(CNT_W), .HAS_RELOAD(1'b1)) t1_cnt_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (t1_tick_i),
    .load_i       (w_t1_hi),
    .load_val_i   (t1_lat_d),
    .reload_en_i  (mode_free),
    .reload_val_i (t1_lat),
    .cnt_o        (t1_cnt),
    .expire_o     (t1_exp)
  );

  dual_tmr_cnt #(.CNT_W(CNT_W), .HAS_RELOAD(1'b0)) t2_cnt_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (t2_tick_i),
    .load_i       (w_t2_hi),
    .load_val_i   (t2_lat_d),
    .reload_en_i  (1'b0),
    .reload_val_i (t2_lat),
    .cnt_o        (t2_cnt),
    .expire_o     (t2_exp)
  );

  logic [NUM_SRC-1:0] flg_set, flg_clr, flags, en;

  always_comb begin
    flg_set         = '0;
    flg_set[FLG_SR] = sr_evt_i;
    flg_set[FLG_T2] = t2_exp;
    flg_set[FLG_T1] = t1_exp;
    flg_clr         = {NUM_SRC{w_flag}} & wdata_i[NUM_SRC-1:0];
    flg_clr[FLG_T2] = flg_clr[FLG_T2] | w_t2_hi | r_t2_lo;
    flg_clr[FLG_T1] = flg_clr[FLG_T1] | w_t1_hi | r_t1_lo;
  end

  dual_tmr_irq #(.NUM_SRC(NUM_SRC)) irq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (flg_set),
    .clr_i     (flg_clr),
    .en_wr_i   (w_mask),
    .en_set_i  (wdata_i[DATA_W-1]),
    .en_bits_i (wdata_i[NUM_SRC-1:0]),
    .flags_o   (flags),
    .en_o      (en),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (hit(addr_i, A_T1_LO))     rdata_o = t1_cnt[DATA_W-1:0];
      if (hit(addr_i, A_T1_HI))     rdata_o = t1_cnt[CNT_W-1:DATA_W];
      if (hit(addr_i, A_T1_LAT_LO)) rdata_o = t1_lat[DATA_W-1:0];
      if (hit(addr_i, A_T1_LAT_HI)) rdata_o = t1_lat[CNT_W-1:DATA_W];
      if (hit(addr_i, A_T2_LO))     rdata_o = t2_cnt[DATA_W-1:0];
      if (hit(addr_i, A_T2_HI))     rdata_o = t2_cnt[CNT_W-1:DATA_W];
      if (hit(addr_i, A_MODE))      rdata_o[0] = mode_free;
      if (hit(addr_i, A_FLAG)) begin
        rdata_o[NUM_SRC-1:0] = flags;
        rdata_o[DATA_W-1]    = |(flags & en);
      end
      if (hit(addr_i, A_MASK))      rdata_o[NUM_SRC-1:0] = en;
    end
  end
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk
  import dual_tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  t1_tick_i,
  input logic                  t2_tick_i,
  input logic                  wr_en_i,
  input logic                  rd_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [2*DATA_W-1:0]   t1_cnt,
  input logic [2*DATA_W-1:0]   t2_cnt,
  input logic [2*DATA_W-1:0]   t1_lat,
  input logic [DATA_W-1:0]     t2_lat_lo,
  input logic [NUM_SRC-1:0]    flags,
  input logic                  mode_free
);
  localparam int CNT_W = 2 * DATA_W;

  logic wr_t2_lo, wr_t2_hi, rd_t2_lo, rd_t2_hi, wr_t1_hi;
  assign wr_t2_lo = wr_en_i && addr_i == ADDR_W'(A_T2_LO);
  assign wr_t2_hi = wr_en_i && addr_i == ADDR_W'(A_T2_HI);
  assign rd_t2_lo = rd_en_i && addr_i == ADDR_W'(A_T2_LO);
  assign rd_t2_hi = rd_en_i && addr_i == ADDR_W'(A_T2_HI);
  assign wr_t1_hi = wr_en_i && addr_i == ADDR_W'(A_T1_HI);

  assert_t2_stage_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_t2_lo && !t2_tick_i) |=> ($stable(t2_cnt) && $stable(flags[FLG_T2])));

  assert_t2_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_t2_hi |=> (t2_cnt == $past({wdata_i, t2_lat_lo}) && !flags[FLG_T2]));

  assert_t2_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_t2_lo && !t2_tick_i) |=> !flags[FLG_T2]);

  assert_t2_hi_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_t2_hi && !t2_tick_i) |=> $stable(flags[FLG_T2]));

  assert_t2_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t2_tick_i && !wr_t2_hi && t2_cnt != '0) |=> t2_cnt == $past(t2_cnt) - CNT_W'(1));

  assert_t1_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1_tick_i && mode_free && t1_cnt == '0 && !wr_t1_hi)
      |=> (t1_cnt == $past(t1_lat) && flags[FLG_T1]));
endmodule

bind dual_tmr dual_tmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .t1_tick_i (t1_tick_i),
  .t2_tick_i (t2_tick_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .t1_cnt    (t1_cnt),
  .t2_cnt    (t2_cnt),
  .t1_lat    (t1_lat),
  .t2_lat_lo (t2_lat[DATA_W-1:0]),
  .flags     (flags),
  .mode_free (mode_free)
);

// File: tb/dual_tmr_tb_top.sv
`timescale 1ns/1ps
module dual_tmr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       t1_tick = 1'b0, t2_tick = 1'b0, sr_evt = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  dual_tmr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .t1_tick_i(t1_tick), .t2_tick_i(t2_tick),
    .sr_evt_i(sr_evt), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic tick(input bit which2, input int n);
    if (n > 0) begin
      @(negedge clk);
      if (which2) t2_tick = 1'b1; else t1_tick = 1'b1;
      repeat (n) @(negedge clk);
      t1_tick = 1'b0; t2_tick = 1'b0;
    end
  endtask

  task automatic rd_chk(input logic [3:0] a, input int exp, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(v == exp[7:0], req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rd_chk(1, 8'hFF, "R1 t1 cnt hi");
    rd_chk(0, 8'hFF, "R1 t1 cnt lo");
    rd_chk(2, 8'hFF, "R1 t1 lat lo");
    rd_chk(3, 8'hFF, "R1 t1 lat hi");
    rd_chk(5, 8'hFF, "R1 t2 cnt hi");
    rd_chk(4, 8'hFF, "R1 t2 cnt lo");
    rd_chk(6, 8'h00, "R1 mode");
    rd_chk(7, 8'h00, "R1 flags");
    rd_chk(8, 8'h00, "R1 enables");
    wr(5, 8'h12);                       // R1: latch low still 0xFF
    rd_chk(4, 8'hFF, "R1 t2 lat lo reset");
    rd_chk(5, 8'h12, "R3 t2 hi load");

    // R2..R6 sweep over small timer-2 loads
    for (int l = 0; l < 7; l++) begin
      wr(4, 8'(l));
      rd_chk(4, 8'hFF, "R2 lo write no load");
      wr(5, 8'h00);
      rd_chk(5, 8'h00, "R3 cnt hi");
      rd_chk(4, l, "R3 cnt lo");
      tick(1'b0, 3);                    // R6: timer-1 ticks leave timer 2
      rd_chk(4, l, "R6 no count on t1 tick");
      tick(1'b1, l);
      rd_chk(4, 8'h00, "R6 reached zero");
      rd_chk(7, 8'h00, "R6 no flag at zero");
      tick(1'b1, 1);
      rd_chk(7, 8'h02, "R6 flag on crossing");
      wr(4, 8'h33);
      rd_chk(7, 8'h02, "R2 flag kept");
      rd_chk(5, 8'hFF, "R5 wrap hi");
      rd_chk(7, 8'h02, "R5 no side effect");
      rd_chk(4, 8'hFF, "R4 wrap lo");
      rd_chk(7, 8'h00, "R4 ack");
    end

    // R4 irq drops right after acknowledge; R12
    wr(4, 8'h00); wr(5, 8'h00);
    wr(8, 8'h82);
    tick(1'b1, 1);
    chk(irq == 1'b1, "R12 irq t2", irq, 1);
    rd(4, v);
    chk(irq == 1'b0, "R4 irq after ack", irq, 0);

    // R3 high write clears pending flag
    wr(5, 8'h00);
    tick(1'b1, 1);
    chk(irq == 1'b1, "R3 setup", irq, 1);
    wr(5, 8'h01);
    chk(irq == 1'b0, "R3 flag cleared", irq, 0);
    rd_chk(5, 8'h01, "R3 reload hi");

    // R6 once per load across a full wrap
    wr(5, 8'h00);
    tick(1'b1, 1);
    wr(7, 8'h02);
    rd_chk(7, 8'h00, "R10 write-one clear");
    tick(1'b1, 65536);
    rd_chk(5, 8'hFF, "R6 full wrap hi");
    rd_chk(7, 8'h00, "R6 no second flag");
    wr(8, 8'h02);

    // R7 timer-1 one-shot
    wr(0, 8'h03);
    wr(1, 8'h00);
    rd_chk(1, 8'h00, "R9 t1 load hi");
    rd_chk(0, 8'h03, "R9 t1 load lo");
    tick(1'b0, 3);
    rd_chk(7, 8'h00, "R7 no flag before crossing");
    tick(1'b0, 1);
    rd_chk(7, 8'h04, "R7 flag");
    rd_chk(1, 8'hFF, "R7 wrap");
    rd_chk(0, 8'hFF, "R9 lo read");
    rd_chk(7, 8'h00, "R9 lo read clears");
    tick(1'b0, 4);
    rd_chk(0, 8'hFB, "R7 keeps counting");
    rd_chk(7, 8'h00, "R7 one flag only");

    // R8 free-running
    wr(6, 8'h01);
    rd_chk(6, 8'h01, "R8 mode");
    wr(2, 8'h02);
    wr(1, 8'h00);
    for (int p = 0; p < 3; p++) begin
      tick(1'b0, 2);
      rd_chk(7, 8'h00, "R8 mid period");
      tick(1'b0, 1);
      rd_chk(7, 8'h04, "R8 flag each period");
      rd_chk(1, 8'h00, "R8 reload hi");
      rd_chk(0, 8'h02, "R8 reload lo");
    end
    tick(1'b0, 3);
    wr(8, 8'h84);
    chk(irq == 1'b1, "R9 setup", irq, 1);
    wr(1, 8'h00);
    chk(irq == 1'b0, "R9 hi write clears", irq, 0);
    wr(6, 8'h00);

    // R10..R13 all flag / enable combinations
    for (int en = 0; en < 8; en++) begin
      for (int fm = 0; fm < 8; fm++) begin
        wr(2, 8'h00); wr(1, 8'h00);
        wr(4, 8'h00); wr(5, 8'h00);
        @(negedge clk); t1_tick = 1'b1; t2_tick = 1'b1; sr_evt = 1'b1;
        @(negedge clk); t1_tick = 1'b0; t2_tick = 1'b0; sr_evt = 1'b0;
        wr(8, 8'h07);
        rd_chk(7, 8'h07, "R13 all flags set");
        wr(8, 8'(8'h80 | en));
        rd_chk(8, en, "R11 set");
        wr(7, 8'(~fm & 7));
        rd_chk(7, ((|(fm & en)) << 7) | fm, "R10 flags and bit7");
        chk(irq == (|(fm & en)), "R12 irq", irq, int'(|(fm & en)));
        wr(8, 8'h01);
        rd_chk(8, en & 6, "R11 clear");
        wr(7, 8'h07);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule